// File: doc/BRIEF.md
# Page event counter bank

This block keeps four 32-bit event counts, each tied to one of the four top pages (12 through 15) of a sixteen-page memory. The counters for pages 12 and 13 step once for every committed write into their page. The counter for page 14 counts falling edges on external trigger pin A, and the counter for page 15 counts falling edges on pin B. Both pins are active low, asynchronous and noisy, so each one passes through its own synchronizer and stability filter before it is counted.

The memory controller reports each completed page copy as one strobe cycle carrying the page number. A read port returns the count for any page number. Pages that have no counter read as all ones. There is no write path to the counts. They clear only on the power-on reset, and they wrap when they pass their maximum.

Top module: `page_event_counter_bank`

## Requirements
- R1: After power-on reset, the counts read for pages 12, 13, 14 and 15 are all 0.
- R2: A read of any page number from 0 to 11 returns all ones (32'hFFFF_FFFF).
- R3: Each cycle in which `wr_commit` is 1 with `wr_page` equal to 12 adds exactly one to the page 12 count. A strobe with `wr_page` equal to 13 adds one to the page 13 count in the same way. No other count changes.
- R4: A strobe with `wr_page` equal to 14, 15 or any value from 0 to 11 leaves all four counts unchanged.
- R5: A level of 0 on `trig_a_n` that lasts at least `DEB_CYCLES` consecutive clock samples adds exactly one to the page 14 count and leaves the page 15 count unchanged.
- R6: A qualified low level on `trig_b_n` adds exactly one to the page 15 count and leaves the page 14 count unchanged.
- R7: A low pulse on a trigger pin shorter than `DEB_CYCLES` samples does not change any count.
- R8: The return of a trigger pin from low to high never changes a count. A new event on that pin requires it to be high for `DEB_CYCLES` samples and then low again for `DEB_CYCLES` samples.
- R9: A count that holds its all-ones value wraps to 0 on its next increment.
- R10: The read port is combinational. A commit strobe sampled at a clock edge is visible in `rd_count` right after that edge. A strobe held for n consecutive cycles counts n times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; clears all counts |
| wr_commit | input | 1 | One-cycle strobe marking a completed copy into a page |
| wr_page | input | PAGE_W | Page number of the committed copy |
| trig_a_n | input | 1 | Raw asynchronous active-low trigger A (page 14 counter) |
| trig_b_n | input | 1 | Raw asynchronous active-low trigger B (page 15 counter) |
| rd_page | input | PAGE_W | Page whose count is read |
| rd_count | output | CNT_W | Count for `rd_page`, or all ones when the page has no counter |

## Verification
The properties assume that `wr_commit` is a clean synchronous strobe with a valid `wr_page` in the same cycle. They also assume that the trigger pins are idle high after reset, so that a page 14 or 15 count can only move by plus one per cycle. The stimulus drives every input at the falling clock edge. It holds trigger levels either well beyond the filter window or well short of it, so no event falls near the qualification boundary. The wrap check uses a second, narrow copy of the block, because the 32-bit counts cannot reach their maximum in a practical run.

// File: rtl/pecb_pkg.sv
package pecb_pkg;

    localparam int unsigned NUM_SLOTS = 4;
    localparam int unsigned NUM_EXT   = 2;

    typedef enum logic [1:0] {
        SRC_WRITE = 2'd0,
        SRC_EXT_A = 2'd1,
        SRC_EXT_B = 2'd2
    } slot_src_e;

    // Source of each counter slot; slot i belongs to page FIRST_PAGE + i.
    function automatic slot_src_e slot_src(input int unsigned slot);
        case (slot)
            2:       return SRC_EXT_A;
            3:       return SRC_EXT_B;
            default: return SRC_WRITE;
        endcase
    endfunction

endpackage

// File: rtl/pecb_debounce.sv
module pecb_debounce #(
    parameter int unsigned DEB_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall_o
);

    localparam int unsigned TW = $clog2(DEB_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(DEB_CYCLES - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          level;
        logic [TW-1:0] run;
        logic          fall;
    } deb_t;

    deb_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_n;
        st_d.s2   = st_q.s1;
        st_d.fall = 1'b0;
        if (st_q.s2 != st_q.level) begin
            if (st_q.run == LAST) begin
                st_d.level = st_q.s2;
                st_d.run   = '0;
                st_d.fall  = ~st_q.s2;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b1, s2: 1'b1, level: 1'b1, run: '0, fall: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_o = st_q.fall;

endmodule

// File: rtl/pecb_counter.sv
module pecb_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i) begin
            cnt_d.value = cnt_q.value + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '{value: '0};
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q.value;

endmodule

// File: rtl/page_event_counter_bank.sv
module page_event_counter_bank
    import pecb_pkg::*;
#(
    parameter int unsigned PAGE_W     = 4,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned FIRST_PAGE = 12,
    parameter int unsigned DEB_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_commit,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic              trig_a_n,
    input  logic              trig_b_n,
    input  logic [PAGE_W-1:0] rd_page,
    output logic [CNT_W-1:0]  rd_count
);

    localparam int unsigned LAST_PAGE = FIRST_PAGE + NUM_SLOTS - 1;

    if (LAST_PAGE >= (1 << PAGE_W)) begin : g_bad_map
        initial $error("counter pages exceed the page number range");
    end

    logic [NUM_EXT-1:0]              pin_n;
    logic [NUM_EXT-1:0]              ext_fall;
    logic [NUM_SLOTS-1:0]            slot_inc;
    logic [NUM_SLOTS-1:0][CNT_W-1:0] cnt_q;

    assign pin_n = {trig_b_n, trig_a_n};

    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
        pecb_debounce #(
            .DEB_CYCLES(DEB_CYCLES)
        ) u_deb (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_n (pin_n[e]),
            .fall_o(ext_fall[e])
        );
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam logic [PAGE_W-1:0] SLOT_PAGE = PAGE_W'(FIRST_PAGE + i);
        if (slot_src(i) == SRC_WRITE) begin : g_wr
            assign slot_inc[i] = wr_commit && (wr_page == SLOT_PAGE);
        end else if (slot_src(i) == SRC_EXT_A) begin : g_a
            assign slot_inc[i] = ext_fall[0];
        end else begin : g_b
            assign slot_inc[i] = ext_fall[1];
        end

        pecb_counter #(
            .CNT_W(CNT_W)
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc_i  (slot_inc[i]),
            .count_o(cnt_q[i])
        );
    end

    always_comb begin
        rd_count = '1;
        for (int unsigned i = 0; i < NUM_SLOTS; i++) begin
            if (rd_page == PAGE_W'(FIRST_PAGE + i)) begin
                rd_count = cnt_q[i];
            end
        end
    end

endmodule

// File: rtl/pecb_checker.sv
module pecb_checker
    import pecb_pkg::*;
#(
    parameter int unsigned PAGE_W     = 4,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned FIRST_PAGE = 12
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             wr_commit,
    input logic [PAGE_W-1:0]                wr_page,
    input logic [PAGE_W-1:0]                rd_page,
    input logic [CNT_W-1:0]                 rd_count,
    input logic [NUM_SLOTS-1:0][CNT_W-1:0]  cnt_q
);

    localparam logic [PAGE_W-1:0] PG0 = PAGE_W'(FIRST_PAGE);
    localparam logic [PAGE_W-1:0] PG1 = PAGE_W'(FIRST_PAGE + 1);

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt_q == '0));

    p_miss_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_page < PG0) |-> (rd_count == '1));

    p_commit_step0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && wr_page == PG0) |=> (cnt_q[0] == $past(cnt_q[0]) + 1'b1));

    p_commit_step1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && wr_page == PG1) |=> (cnt_q[1] == $past(cnt_q[1]) + 1'b1));

    p_write_hold0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_commit && wr_page == PG0) |=> $stable(cnt_q[0]));

    p_write_hold1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_commit && wr_page == PG1) |=> $stable(cnt_q[1]));

    p_ext_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q[2]) |-> (cnt_q[2] == $past(cnt_q[2]) + 1'b1));

    p_ext_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q[3]) |-> (cnt_q[3] == $past(cnt_q[3]) + 1'b1));

    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && wr_page == PG0 && cnt_q[0] == '1) |=> (cnt_q[0] == '0));

endmodule

bind page_event_counter_bank pecb_checker #(
    .PAGE_W    (PAGE_W),
    .CNT_W     (CNT_W),
    .FIRST_PAGE(FIRST_PAGE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_commit(wr_commit),
    .wr_page  (wr_page),
    .rd_page  (rd_page),
    .rd_count (rd_count),
    .cnt_q    (cnt_q)
);

// File: tb/tb_page_event_counter_bank.sv
module tb_page_event_counter_bank;

    localparam int unsigned DEB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_commit = 1'b0;
    logic [3:0] wr_page = 4'd0;
    logic       trig_a_n = 1'b1;
    logic       trig_b_n = 1'b1;
    logic [3:0] rd_page = 4'd0;
    logic [31:0] rd_count;
    logic [3:0]  rd_count_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    page_event_counter_bank #(.DEB_CYCLES(DEB)) dut (
        .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .wr_page(wr_page),
        .trig_a_n(trig_a_n), .trig_b_n(trig_b_n), .rd_page(rd_page),
        .rd_count(rd_count)
    );

    page_event_counter_bank #(.CNT_W(4), .DEB_CYCLES(DEB)) dut_narrow (
        .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .wr_page(wr_page),
        .trig_a_n(trig_a_n), .trig_b_n(trig_b_n), .rd_page(rd_page),
        .rd_count(rd_count_n)
    );

    typedef struct packed {
        logic        is_read;
        logic [3:0]  page;
        logic [31:0] expv;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 4'd12, 32'd0},          // R1
        '{1'b1, 4'd13, 32'd0},          // R1
        '{1'b1, 4'd14, 32'd0},          // R1
        '{1'b1, 4'd15, 32'd0},          // R1
        '{1'b1, 4'd0,  32'hFFFF_FFFF},  // R2
        '{1'b1, 4'd11, 32'hFFFF_FFFF},  // R2
        '{1'b0, 4'd12, 32'd0},
        '{1'b1, 4'd12, 32'd1},          // R3
        '{1'b1, 4'd13, 32'd0},          // R3
        '{1'b0, 4'd13, 32'd0},
        '{1'b0, 4'd13, 32'd0},
        '{1'b1, 4'd13, 32'd2},          // R3
        '{1'b0, 4'd14, 32'd0},
        '{1'b0, 4'd15, 32'd0},
        '{1'b0, 4'd5,  32'd0},
        '{1'b1, 4'd14, 32'd0},          // R4
        '{1'b1, 4'd15, 32'd0},          // R4
        '{1'b1, 4'd12, 32'd1},          // R4
        '{1'b1, 4'd13, 32'd2},          // R4
        '{1'b1, 4'd5,  32'hFFFF_FFFF}   // R2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic read_check(input string req, input logic [3:0] pg, input logic [31:0] expv);
        rd_page = pg;
        #1;
        check(req, rd_count, expv);
    endtask

    task automatic commit(input logic [3:0] pg, input int n);
        wr_page   = pg;
        wr_commit = 1'b1;
        repeat (n) @(negedge clk);
        wr_commit = 1'b0;
    endtask

    task automatic pulse(input bit use_b, input int low_len);
        if (use_b) trig_b_n = 1'b0; else trig_a_n = 1'b0;
        repeat (low_len) @(negedge clk);
        if (use_b) trig_b_n = 1'b1; else trig_a_n = 1'b1;
        repeat (DEB + 10) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int w12;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NVEC; k++) begin
            if (VECS[k].is_read) begin
                read_check("R1-4 table", VECS[k].page, VECS[k].expv);
            end else begin
                commit(VECS[k].page, 1);
            end
        end
        w12 = 1;

        // R5: qualified low on A
        pulse(1'b0, DEB + 4);
        read_check("R5", 4'd14, 32'd1);
        read_check("R5", 4'd15, 32'd0);

        // R6: qualified low on B
        pulse(1'b1, DEB + 4);
        read_check("R6", 4'd15, 32'd1);
        read_check("R6", 4'd14, 32'd1);

        // R7: glitches shorter than the window
        pulse(1'b0, DEB - 4);
        pulse(1'b1, DEB / 2);
        read_check("R7", 4'd14, 32'd1);
        read_check("R7", 4'd15, 32'd1);

        // R8: long low, check before and after release
        trig_a_n = 1'b0;
        repeat (DEB + 10) @(negedge clk);
        read_check("R8", 4'd14, 32'd2);
        trig_a_n = 1'b1;
        repeat (DEB + 10) @(negedge clk);
        read_check("R8", 4'd14, 32'd2);

        // R10: same-edge visibility and a strobe held three cycles
        rd_page   = 4'd12;
        wr_page   = 4'd12;
        wr_commit = 1'b1;
        @(posedge clk);
        #1;
        check("R10", rd_count, 32'(w12 + 1));
        @(negedge clk);
        repeat (2) @(negedge clk);
        wr_commit = 1'b0;
        w12 += 3;
        read_check("R10", 4'd12, 32'(w12));

        // R9: the narrow copy wraps 15 -> 0
        commit(4'd12, 15 - (w12 % 16));
        w12 += 15 - (w12 % 16);
        rd_page = 4'd12;
        #1;
        check("R9", {28'd0, rd_count_n}, 32'd15);
        commit(4'd12, 1);
        w12 += 1;
        rd_page = 4'd12;
        #1;
        check("R9", {28'd0, rd_count_n}, 32'd0);
        check("R9", rd_count, 32'(w12));

        // R1: reset clears everything again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_check("R1", 4'd12, 32'd0);
        read_check("R1", 4'd13, 32'd0);
        read_check("R1", 4'd14, 32'd0);
        read_check("R1", 4'd15, 32'd0);

        finish_run();
    end

endmodule